// File: doc/BRIEF.md
# Resumable Masked Vector Element Sequencer

This block walks the element positions of one vector operation, one position per clock. A job is launched with a vector count C and a resume index X. X is the position where a previously interrupted operation stopped, and it is zero for a fresh operation. The block then steps through positions X, X+1, ... up to C-1. For every position it raises a step strobe, so that address generation can advance, and an element enable that tells the datapath whether to write a result.

The enable is always high for instructions of the mask-independent class, and for any instruction when mask mode is off. For the mask-controlled class with mask mode on, the enable follows the bit of the captured mask register that sits at the stepped position. If C does not exceed X, there is nothing to do: the job finishes at once with the resume index cleared.

An interrupt request is honoured only at an element boundary. The block then stops and reports the position of the next unprocessed element, so that a later job can resume from it.

Top module: `vec_elem_seq`

## Requirements
- R1: A start accepted while idle with count_i > first_idx_i makes step_o high in each of the following cycles, with step_idx_o running first_idx_i, first_idx_i+1, ... in ascending order. The first step appears in the cycle after the start, and busy_o is high while stepping.
- R2: A start accepted with count_i <= first_idx_i issues no step. done_o is high in the next cycle, and resume_idx_o reads 0 from then on.
- R3: After the step at position count_i-1, done_o is high for exactly one cycle in the next cycle, busy_o is low, and resume_idx_o reads 0.
- R4: intr_req_i is sampled at the end of each step cycle. If it is high and that step was not the last, stepping stops and intr_o pulses for one cycle in the next cycle. resume_idx_o then holds Y, the index of the next unprocessed element, so exactly Y-X steps were issued.
- R5: An interrupt request during the step of position count_i-1 has no effect. The job completes with done_o, and intr_o stays low.
- R6: When mask_mode_i and mask_class_i were both 1 at start, elem_en_o during a step equals bit step_idx_o of the mask_i captured at start (bit i belongs to element i).
- R7: When either mask_mode_i or mask_class_i was 0 at start, elem_en_o is 1 on every step, whatever the mask holds.
- R8: A position whose mask bit is 0 still produces a step (step_o high, elem_en_o low). elem_en_o is never high without step_o.
- R9: start_i is ignored while busy_o is high. The running job's step sequence and outcome are unchanged.
- R10: After reset, busy_o, step_o, elem_en_o, done_o and intr_o are 0, and resume_idx_o is 0.
- R11: resume_idx_o keeps its value while idle until the next done_o or intr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a job (accepted only when idle) |
| count_i | input | 9 | Vector count C, 0 to 256 |
| first_idx_i | input | 8 | Resume index X |
| mask_i | input | 256 | Vector mask, bit i for element i |
| mask_mode_i | input | 1 | Mask mode on |
| mask_class_i | input | 1 | Instruction belongs to the mask-controlled class |
| intr_req_i | input | 1 | Interrupt request, sampled at element boundaries |
| busy_o | output | 1 | Job is stepping |
| step_o | output | 1 | One element position is being processed |
| step_idx_o | output | 8 | Position of the current step |
| elem_en_o | output | 1 | Result write enable for the current step |
| done_o | output | 1 | Job completed (one-cycle pulse) |
| intr_o | output | 1 | Job interrupted (one-cycle pulse) |
| resume_idx_o | output | 8 | Next unprocessed position, 0 after completion |

## Verification
The assertions assume that start_i, count_i, first_idx_i, the mask and the mode bits are only meaningful in the cycle a start is accepted, and that count_i never exceeds 256. The checker captures them at that moment and judges steps, pulses and the resume index against the captured values. The stimulus changes inputs only between clock edges and keeps count_i within 0 to 256. It raises intr_req_i only for the single step cycle chosen as the interrupt point, and it pokes start_i with unrelated values only while busy_o is high.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } seq_state_e;

   function automatic int unsigned mask_width(input int unsigned idx_w);
      return 32'd1 << idx_w;
   endfunction
endpackage

// File: rtl/vseq_netcount.sv
module vseq_netcount #(
   parameter int unsigned IDX_W = 8,
   localparam int unsigned CNT_W = IDX_W + 1
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic [IDX_W-1:0] first_i,
   output logic             empty_o
);
   logic [CNT_W-1:0] first_ext;

   assign first_ext = {1'b0, first_i};
   // nothing to process when the count does not exceed the resume index
   assign empty_o   = (count_i <= first_ext);
endmodule

// File: rtl/vseq_mask_sel.sv
module vseq_mask_sel #(
   parameter int unsigned IDX_W      = 8,
   parameter bit          PICK_ONEHOT = 1'b0,
   localparam int unsigned MASK_W    = vseq_pkg::mask_width(IDX_W)
) (
   input  logic [MASK_W-1:0] mask_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic              bit_o
);
   generate
      if (PICK_ONEHOT) begin : g_onehot
         logic [MASK_W-1:0] sel;
         assign sel   = MASK_W'(1) << idx_i;
         assign bit_o = |(mask_i & sel);
      end else begin : g_mux
         assign bit_o = mask_i[idx_i];
      end
   endgenerate
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
   import vseq_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   localparam int unsigned CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic             empty_i,
   input  logic [CNT_W-1:0] count_i,
   input  logic [IDX_W-1:0] first_i,
   input  logic             intr_req_i,
   output logic             busy_o,
   output logic [IDX_W-1:0] cur_o,
   output logic             done_o,
   output logic             intr_o,
   output logic [IDX_W-1:0] resume_o
);
   seq_state_e       state_q;
   logic [IDX_W-1:0] cur_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic             last;
   logic             done_q;
   logic             intr_q;
   logic [IDX_W-1:0] resume_q;

   assign nxt  = {1'b0, cur_q} + CNT_W'(1);
   assign last = (nxt == cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cur_q    <= '0;
         cnt_q    <= '0;
         done_q   <= 1'b0;
         intr_q   <= 1'b0;
         resume_q <= '0;
      end else begin
         done_q <= 1'b0;
         intr_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept_i) begin
                  if (empty_i) begin
                     done_q   <= 1'b1;
                     resume_q <= '0;
                  end else begin
                     state_q <= ST_RUN;
                     cur_q   <= first_i;
                     cnt_q   <= count_i;
                  end
               end
            end
            ST_RUN: begin
               if (last) begin
                  state_q  <= ST_IDLE;
                  done_q   <= 1'b1;
                  resume_q <= '0;
               end else if (intr_req_i) begin
                  state_q  <= ST_IDLE;
                  intr_q   <= 1'b1;
                  resume_q <= nxt[IDX_W-1:0];
               end else begin
                  cur_q <= nxt[IDX_W-1:0];
               end
            end
         endcase
      end
   end

   assign busy_o   = (state_q == ST_RUN);
   assign cur_o    = cur_q;
   assign done_o   = done_q;
   assign intr_o   = intr_q;
   assign resume_o = resume_q;
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
   parameter int unsigned IDX_W       = 8,
   parameter bit          PICK_ONEHOT = 1'b0,
   localparam int unsigned CNT_W      = IDX_W + 1,
   localparam int unsigned MASK_W     = vseq_pkg::mask_width(IDX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [IDX_W-1:0]  first_idx_i,
   input  logic [MASK_W-1:0] mask_i,
   input  logic              mask_mode_i,
   input  logic              mask_class_i,
   input  logic              intr_req_i,
   output logic              busy_o,
   output logic              step_o,
   output logic [IDX_W-1:0]  step_idx_o,
   output logic              elem_en_o,
   output logic              done_o,
   output logic              intr_o,
   output logic [IDX_W-1:0]  resume_idx_o
);
   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_width
         $error("vec_elem_seq: IDX_W must lie in 1..10");
      end
   endgenerate

   logic              accept;
   logic              empty;
   logic              busy;
   logic [IDX_W-1:0]  cur;
   logic [MASK_W-1:0] mask_q;
   logic              gate_q;
   logic              mask_bit;

   assign accept = start_i & ~busy;

   vseq_netcount #(.IDX_W(IDX_W)) u_net (
      .count_i (count_i),
      .first_i (first_idx_i),
      .empty_o (empty)
   );

   vseq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .empty_i    (empty),
      .count_i    (count_i),
      .first_i    (first_idx_i),
      .intr_req_i (intr_req_i),
      .busy_o     (busy),
      .cur_o      (cur),
      .done_o     (done_o),
      .intr_o     (intr_o),
      .resume_o   (resume_idx_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         gate_q <= 1'b0;
      end else if (accept) begin
         mask_q <= mask_i;
         gate_q <= mask_mode_i & mask_class_i;
      end
   end

   vseq_mask_sel #(.IDX_W(IDX_W), .PICK_ONEHOT(PICK_ONEHOT)) u_sel (
      .mask_i (mask_q),
      .idx_i  (cur),
      .bit_o  (mask_bit)
   );

   assign busy_o     = busy;
   assign step_o     = busy;
   assign step_idx_o = cur;
   assign elem_en_o  = busy & (~gate_q | mask_bit);
endmodule

// File: rtl/vec_elem_seq_chk.sv
module vec_elem_seq_chk #(
   parameter int unsigned IDX_W = 8,
   localparam int unsigned CNT_W = IDX_W + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [CNT_W-1:0] count_i,
   input logic [IDX_W-1:0] first_idx_i,
   input logic             mask_mode_i,
   input logic             mask_class_i,
   input logic             intr_req_i,
   input logic             busy_o,
   input logic             step_o,
   input logic [IDX_W-1:0] step_idx_o,
   input logic             elem_en_o,
   input logic             done_o,
   input logic             intr_o,
   input logic [IDX_W-1:0] resume_idx_o
);
   logic             acc;
   logic [CNT_W-1:0] cap_cnt;
   logic [IDX_W-1:0] cap_first;
   logic             cap_gate;

   assign acc = start_i && !busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_cnt   <= '0;
         cap_first <= '0;
         cap_gate  <= 1'b0;
      end else if (acc) begin
         cap_cnt   <= count_i;
         cap_first <= first_idx_i;
         cap_gate  <= mask_mode_i && mask_class_i;
      end
   end

   a_r1_first_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && count_i > {1'b0, first_idx_i}) |=> (step_o && step_idx_o == cap_first));

   a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && $past(step_o)) |-> (step_idx_o == $past(step_idx_o) + 1'b1));

   a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      step_o |-> ({1'b0, step_idx_o} < cap_cnt && step_idx_o >= cap_first));

   a_r2_zero_net: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && count_i <= {1'b0, first_idx_i}) |=> (done_o && !step_o && resume_idx_o == '0));

   a_r3_done_state: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && resume_idx_o == '0));

   a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> !done_o);

   a_r4_intr_index: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |-> (resume_idx_o > cap_first && {1'b0, resume_idx_o} < cap_cnt && !busy_o));

   a_r4_intr_source: assert property (@(posedge clk) disable iff (!rst_n)
      intr_o |-> ($past(step_o) && $past(intr_req_i)));

   a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && intr_o));

   a_r7_ungated: assert property (@(posedge clk) disable iff (!rst_n)
      (step_o && !cap_gate) |-> elem_en_o);

   a_r8_en_with_step: assert property (@(posedge clk) disable iff (!rst_n)
      elem_en_o |-> step_o);

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_o && !intr_o && $past(!busy_o)) |-> $stable(resume_idx_o));
endmodule

bind vec_elem_seq vec_elem_seq_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;
   localparam int IDX_W  = 8;
   localparam int CNT_W  = IDX_W + 1;
   localparam int MASK_W = 1 << IDX_W;

   typedef struct {
      int    kind;   // 0 step, 1 done, 2 interrupt
      int    idx;
      bit    en;
      string req;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [CNT_W-1:0]  count_i = '0;
   logic [IDX_W-1:0]  first_idx_i = '0;
   logic [MASK_W-1:0] mask_i = '0;
   logic              mask_mode_i = 1'b0;
   logic              mask_class_i = 1'b0;
   logic              intr_req_i = 1'b0;
   logic              busy_o, step_o, elem_en_o, done_o, intr_o;
   logic [IDX_W-1:0]  step_idx_o, resume_idx_o;

   int   checks = 0;
   int   fails  = 0;
   bit   finished = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   vec_elem_seq uut (.*);

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // monitor: pops scoreboard items as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (step_o || done_o || intr_o) begin
            if (q.size() == 0) begin
               check(1'b0, "R9", "unexpected activity kind", int'(step_o) + 2 * int'(done_o), 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               if (e.kind == 0) begin
                  check(step_o, e.req, "step_o", int'(step_o), 1);
                  check(step_idx_o == e.idx, e.req, "step_idx_o", int'(step_idx_o), e.idx);
                  check(elem_en_o == e.en, e.req, "elem_en_o", int'(elem_en_o), int'(e.en));
               end else if (e.kind == 1) begin
                  check(done_o && !step_o, e.req, "done_o", int'(done_o), 1);
                  check(resume_idx_o == 0, e.req, "resume_idx_o at done", int'(resume_idx_o), 0);
               end else begin
                  check(intr_o && !step_o, e.req, "intr_o", int'(intr_o), 1);
                  check(resume_idx_o == e.idx, e.req, "resume_idx_o at interrupt",
                        int'(resume_idx_o), e.idx);
               end
            end
         end
      end
   end

   // driver: predicts the job outcome, then drives it
   task automatic run_job(input int c, input int x, input logic [MASK_W-1:0] m,
                          input bit mode, input bit cls, input int intr_at,
                          input bit poke, input string req);
      int  exp_resume;
      bit  ended;
      exp_resume = 0;
      if (c <= x) begin
         q.push_back('{1, 0, 1'b0, req});
      end else begin
         bit stopped;
         stopped = 1'b0;
         for (int i = x; i < c && !stopped; i++) begin
            q.push_back('{0, i, (mode && cls) ? m[i] : 1'b1, req});
            if (i == intr_at && i != c - 1) begin
               q.push_back('{2, i + 1, 1'b0, req});
               exp_resume = i + 1;
               stopped = 1'b1;
            end
         end
         if (!stopped) q.push_back('{1, 0, 1'b0, req});
      end
      @(negedge clk);
      start_i      = 1'b1;
      count_i      = CNT_W'(c);
      first_idx_i  = IDX_W'(x);
      mask_i       = m;
      mask_mode_i  = mode;
      mask_class_i = cls;
      ended = 1'b0;
      while (!ended) begin
         @(negedge clk);
         if (done_o || intr_o) ended = 1'b1;
         intr_req_i = step_o && (int'(step_idx_o) == intr_at);
         start_i    = poke && busy_o;
         if (start_i) begin
            count_i     = CNT_W'(3);
            first_idx_i = '0;
            mask_i      = ~m;
            mask_mode_i = ~mode;
         end
      end
      intr_req_i = 1'b0;
      start_i    = 1'b0;
      repeat (3) @(negedge clk);
      check(resume_idx_o == exp_resume, "R11", "resume_idx_o held while idle",
            int'(resume_idx_o), exp_resume);
      check(q.size() == 0, req, "scoreboard drained", q.size(), 0);
   endtask

   initial begin
      logic [MASK_W-1:0] alt;
      logic [MASK_W-1:0] rnd;
      alt = {(MASK_W/2){2'b01}};
      for (int i = 0; i < MASK_W / 32; i++) rnd[i*32 +: 32] = $urandom;
      repeat (3) @(negedge clk);
      check(!busy_o && !step_o && !elem_en_o && !done_o && !intr_o, "R10",
            "outputs in reset", int'(busy_o) + int'(done_o) + int'(intr_o), 0);
      check(resume_idx_o == 0, "R10", "resume_idx_o in reset", int'(resume_idx_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 R8: gated by the alternating mask, zero bits still step
      run_job(8, 0, alt, 1'b1, 1'b1, -1, 1'b0, "R6");
      // R7: mask-independent class, then mode off
      run_job(8, 0, alt, 1'b1, 1'b0, -1, 1'b0, "R7");
      run_job(8, 0, alt, 1'b0, 1'b1, -1, 1'b0, "R7");
      // R4: interrupt at element 9 of 3..19, then resume from 10
      run_job(20, 3, rnd, 1'b1, 1'b1, 9, 1'b0, "R4");
      run_job(20, 10, rnd, 1'b1, 1'b1, -1, 1'b0, "R1");
      // R4: interrupt on the very first element
      run_job(12, 4, alt, 1'b0, 1'b0, 4, 1'b0, "R4");
      // R5: interrupt during the last element is ignored
      run_job(6, 2, alt, 1'b1, 1'b1, 5, 1'b0, "R5");
      // R2: zero net count clears a nonzero resume index
      run_job(9, 1, alt, 1'b0, 1'b0, 2, 1'b0, "R4");
      run_job(5, 5, alt, 1'b1, 1'b1, -1, 1'b0, "R2");
      run_job(0, 0, alt, 1'b1, 1'b1, -1, 1'b0, "R2");
      run_job(3, 7, alt, 1'b0, 1'b0, -1, 1'b0, "R2");
      // R9: full-length gated job with start pokes while busy
      run_job(256, 0, rnd, 1'b1, 1'b1, -1, 1'b1, "R9");
      // R3: single element at the top position
      run_job(256, 255, rnd, 1'b1, 1'b1, -1, 1'b0, "R3");
      run_job(1, 0, '0, 1'b1, 1'b1, -1, 1'b0, "R8");
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule